// File: doc/BRIEF.md
# Configurable Up/Down Timer Counter

This block is a parameterised timer counter (16 bits by default). It advances on a count-clock enable and follows one of three modes. In up mode it counts upward and wraps to zero at a compare value. In triangle mode it climbs to the compare value and then walks back down to zero. In pin-direction mode an external pin sets the direction on every tick.

The same external pin can also gate counting. A stop option halts the counter when it lands on zero, and a software start input re-arms it. The mode, the gate option and the stop option are written through a one-word configuration port. A write that names the forbidden mode is refused and latches an error flag.

The counter reports its value, a one-cycle compare-match pulse, a one-cycle zero pulse and its current direction. The external pin is synchronised with two flip-flops before any use.

Top module: `updn_timer`

## Requirements
- R1: A synchronous active-low reset sets count to 0, shows direction up (`dir_up`=1), leaves the counter stopped, clears `mode_err` and loads up mode with stop-at-zero and no gating.
- R2: The counter moves only on a cycle with `tick`=1 while armed. After reset it stays at 0 whatever `tick` does, until a `start` pulse arms it.
- R3: In up mode (`cfg_wdata[1:0]`=00) each tick adds 1, and a tick taken while count equals `cmp_val` loads 0. The period is therefore `cmp_val`+1 ticks.
- R4: In triangle mode (`cfg_wdata[1:0]`=01) the counter rises until it lands on `cmp_val`, after which `dir_up`=0 and ticks decrement. Once it lands on 0, `dir_up`=1 and ticks increment again.
- R5: In pin-direction mode (`cfg_wdata[1:0]`=10) a tick increments while the synchronised pin is 1 and decrements while it is 0, and `dir_up` follows the pin. Reaching `cmp_val` still pulses `match_pulse` but neither clears nor reverses the count.
- R6: With the gate bit (`cfg_wdata[2]`) at 1, ticks are ignored while the synchronised pin is 0. With it at 0, the pin does not gate.
- R7: With the run-through bit (`cfg_wdata[3]`) at 0, a tick that lands the count on 0 halts the counter, and later ticks leave it at 0. With the bit at 1 the counter keeps running through 0.
- R8: A `start` pulse on a halted counter re-arms it. The direction becomes up in up and triangle modes, and comes from the synchronised pin in pin-direction mode.
- R9: A configuration write with mode 11 changes none of the configuration and sets `mode_err`. `mode_err` stays 1 until reset.
- R10: `match_pulse` and `zero_pulse` are 1 only in the single cycle after a tick lands the count on `cmp_val` or 0, and only when such a tick occurs.
- R11: A change on `ext_pin` first influences a tick taken at the third rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count-clock enable |
| ext_pin | input | 1 | Asynchronous external gate/direction pin |
| cmp_val | input | CNT_W | Compare value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration word: [1:0] mode, [2] gate, [3] run-through |
| start | input | 1 | Re-arm a halted counter |
| count | output | CNT_W | Current count |
| match_pulse | output | 1 | One-cycle compare-match pulse |
| zero_pulse | output | 1 | One-cycle zero pulse |
| dir_up | output | 1 | Current direction, 1 = up |
| mode_err | output | 1 | Sticky forbidden-mode error |

## Verification
A tick sampled at a rising edge shows its new count and any pulse in the cycle that follows that edge. A configuration write or a start pulse likewise takes effect one edge later. A pin change needs two edges to pass the synchroniser and acts on the tick at the third edge.

The bench drives all inputs on falling edges. It reads results at the next falling edge after the edge that consumed them. Before it ticks, it holds each pin change for two full cycles. The synchroniser test walks edge by edge and expects no count change at the first two edges and one increment at the third.

// File: rtl/tmr_pkg.sv
// Shared types for the up/down timer counter.
// Assumes the configuration word is 4 bits: [1:0] mode, [2] gate, [3] run-through.
package tmr_pkg;

    localparam int CFG_W = 4;

    typedef enum logic [1:0] {
        MODE_UP  = 2'b00,
        MODE_TRI = 2'b01,
        MODE_PIN = 2'b10,
        MODE_BAD = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        logic      thru_zero;
        logic      gate_en;
        tmr_mode_e mode;
    } tmr_cfg_t;

endpackage

// File: rtl/tmr_sync.sv
// Multi-flop synchroniser for one asynchronous input bit.
// Assumes STAGES >= 2; the output lags the input by STAGES rising edges.
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];

endmodule

// File: rtl/tmr_cfg.sv
// Configuration holder for the timer counter.
// Refuses a whole write whose mode field is the forbidden code and sets a sticky error.
// Assumes writes are single-cycle strobes.
module tmr_cfg
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output tmr_cfg_t         cfg,
    output logic             err
);

    localparam tmr_cfg_t CFG_RST = '{thru_zero: 1'b0, gate_en: 1'b0, mode: MODE_UP};

    tmr_cfg_t wr_cfg;
    assign wr_cfg = tmr_cfg_t'(wdata);

    // Accept legal writes, flag forbidden ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RST;
            err <= 1'b0;
        end else if (we) begin
            if (wr_cfg.mode == MODE_BAD) err <= 1'b1;
            else                         cfg <= wr_cfg;
        end
    end

endmodule

// File: rtl/tmr_core.sv
// Counter datapath: next-value and direction selection per mode, halt at zero, re-arm.
// Assumes ext_s is already synchronised and cfg is stable registered state.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             ext_s,
    input  tmr_cfg_t         cfg,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             match_p,
    output logic             zero_p,
    output logic             running,
    output logic             step
);

    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W-1:0] cnt_q, nxt;
    logic             dir_q, ndir, run_q, gate_ok;

    assign gate_ok = !cfg.gate_en || ext_s;
    assign step    = run_q && tick && gate_ok;

    // Next count and direction for a tick in the current mode.
    always_comb begin
        nxt  = cnt_q;
        ndir = dir_q;
        case (cfg.mode)
            MODE_UP: begin
                ndir = 1'b1;
                nxt  = (cnt_q == cmp) ? '0 : cnt_q + ONE;
            end
            MODE_TRI: begin
                if (cmp == '0) begin
                    nxt  = '0;
                    ndir = 1'b1;
                end else if (dir_q) begin
                    if (cnt_q == MAXV) begin
                        nxt  = cnt_q - ONE;
                        ndir = 1'b0;
                    end else begin
                        nxt  = cnt_q + ONE;
                        ndir = (nxt < cmp);
                    end
                end else begin
                    if (cnt_q == '0) begin
                        nxt  = ONE;
                        ndir = (ONE < cmp);
                    end else begin
                        nxt  = cnt_q - ONE;
                        ndir = (nxt == '0);
                    end
                end
            end
            MODE_PIN: begin
                ndir = ext_s;
                nxt  = ext_s ? cnt_q + ONE : cnt_q - ONE;
            end
            default: begin
                nxt  = cnt_q;
                ndir = dir_q;
            end
        endcase
    end

    // Count, direction, run state and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            dir_q   <= 1'b1;
            run_q   <= 1'b0;
            match_p <= 1'b0;
            zero_p  <= 1'b0;
        end else begin
            match_p <= step && (nxt == cmp);
            zero_p  <= step && (nxt == '0);
            if (step) begin
                cnt_q <= nxt;
                dir_q <= ndir;
                if ((nxt == '0) && !cfg.thru_zero) run_q <= 1'b0;
            end else if (start && !run_q) begin
                run_q <= 1'b1;
                dir_q <= (cfg.mode == MODE_PIN) ? ext_s : 1'b1;
            end else if (cfg.mode == MODE_UP) begin
                dir_q <= 1'b1;
            end
        end
    end

    assign count   = cnt_q;
    assign running = run_q;
    assign dir_up  = (cfg.mode == MODE_PIN) ? ext_s : dir_q;

endmodule

// File: rtl/updn_timer.sv
// Top of the configurable up/down timer counter.
// Ties the pin synchroniser, the configuration holder and the counter core together.
// Assumes ext_pin is asynchronous and every other input is synchronous to clk.
module updn_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ext_pin,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_wdata,
    input  logic             start,
    output logic [CNT_W-1:0] count,
    output logic             match_pulse,
    output logic             zero_pulse,
    output logic             dir_up,
    output logic             mode_err
);

    logic     ext_s;
    tmr_cfg_t cfg;
    logic     running;
    logic     step;

    tmr_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_pin),
        .q     (ext_s)
    );

    tmr_cfg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .err   (mode_err)
    );

    tmr_core #(.CNT_W(CNT_W)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (start),
        .ext_s   (ext_s),
        .cfg     (cfg),
        .cmp     (cmp_val),
        .count   (count),
        .dir_up  (dir_up),
        .match_p (match_pulse),
        .zero_p  (zero_pulse),
        .running (running),
        .step    (step)
    );

endmodule

// File: rtl/updn_timer_chk.sv
// Property checker for updn_timer, attached through bind.
module updn_timer_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cmp_val,
    input logic [CNT_W-1:0] count,
    input logic             match_pulse,
    input logic             zero_pulse,
    input logic             dir_up,
    input logic             mode_err,
    input logic             ext_s,
    input tmr_cfg_t         cfg,
    input logic             running,
    input logic             step
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && dir_up && !running && !mode_err));

    p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));

    p_up_increment_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cfg.mode == MODE_UP && count != cmp_val) |=> (count == $past(count) + 1'b1));

    p_up_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cfg.mode == MODE_UP && count == cmp_val) |=> (count == '0));

    p_pin_up_ignores_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cfg.mode == MODE_PIN && ext_s) |=> (count == $past(count) + 1'b1));

    p_halt_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_pulse && !$past(cfg.thru_zero)) |-> !running);

    p_restart_up_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(running) && cfg.mode != MODE_PIN) |-> dir_up);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);

    p_mode_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.mode != MODE_BAD);

    p_zero_pulse_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |-> (count == '0));

    p_match_pulse_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (count == $past(cmp_val)));

endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_val     (cmp_val),
    .count       (count),
    .match_pulse (match_pulse),
    .zero_pulse  (zero_pulse),
    .dir_up      (dir_up),
    .mode_err    (mode_err),
    .ext_s       (ext_s),
    .cfg         (cfg),
    .running     (running),
    .step        (step)
);

// File: tb/test_updn_timer.sv
`timescale 1ns/1ps
module test_updn_timer;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         ext_pin = 1'b0;
    logic [W-1:0] cmp_val = '0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_wdata = '0;
    logic         start = 1'b0;
    logic [W-1:0] count;
    logic         match_pulse, zero_pulse, dir_up, mode_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    updn_timer #(.CNT_W(W)) i_updn_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .ext_pin     (ext_pin),
        .cmp_val     (cmp_val),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .start       (start),
        .count       (count),
        .match_pulse (match_pulse),
        .zero_pulse  (zero_pulse),
        .dir_up      (dir_up),
        .mode_err    (mode_err)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; start = 1'b0; cfg_we = 1'b0; ext_pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(input logic [1:0] m, input logic gate, input logic thru);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = {thru, gate, m};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        ext_pin = v;
        repeat (2) @(negedge clk);
    endtask

    // One tick; returns at the falling edge after the consuming rising edge.
    task automatic tick_once();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1", "count", count, 0);
        chk("R1", "dir_up", dir_up, 1);
        chk("R1", "mode_err", mode_err, 0);
        chk("R10", "match idle", match_pulse, 0);
        chk("R10", "zero idle", zero_pulse, 0);
        cmp_val = 16'd5;
        repeat (3) tick_once();
        chk("R2", "count before start", count, 0);
    endtask

    task automatic t_up();
        do_reset();
        write_cfg(2'b00, 1'b0, 1'b1);
        cmp_val = 16'd3;
        pulse_start();
        tick_once(); chk("R2", "first tick", count, 1);
        tick_once(); chk("R3", "up 2", count, 2);
        tick_once(); chk("R3", "up 3", count, 3);
        chk("R10", "match at cmp", match_pulse, 1);
        @(negedge clk); chk("R10", "match one cycle", match_pulse, 0);
        tick_once(); chk("R3", "clear after match", count, 0);
        chk("R10", "zero pulse", zero_pulse, 1);
        tick_once(); chk("R7", "run through zero", count, 1);
        chk("R10", "no zero pulse", zero_pulse, 0);
    endtask

    task automatic t_up_stop();
        do_reset();
        write_cfg(2'b00, 1'b0, 1'b0);
        cmp_val = 16'd2;
        pulse_start();
        tick_once(); tick_once(); tick_once();
        chk("R7", "landed on zero", count, 0);
        tick_once(); tick_once();
        chk("R7", "halted at zero", count, 0);
        chk("R10", "no pulse when halted", zero_pulse, 0);
        pulse_start();
        tick_once(); chk("R8", "restart up", count, 1);
    endtask

    task automatic t_tri();
        do_reset();
        write_cfg(2'b01, 1'b0, 1'b1);
        cmp_val = 16'd3;
        pulse_start();
        tick_once(); tick_once(); tick_once();
        chk("R4", "peak", count, 3);
        chk("R4", "dir down at peak", dir_up, 0);
        chk("R10", "match at peak", match_pulse, 1);
        tick_once(); chk("R4", "descend", count, 2);
        tick_once(); tick_once();
        chk("R4", "valley", count, 0);
        chk("R4", "dir up at valley", dir_up, 1);
        tick_once(); chk("R4", "ascend again", count, 1);
    endtask

    task automatic t_tri_stop();
        do_reset();
        write_cfg(2'b01, 1'b0, 1'b0);
        cmp_val = 16'd2;
        pulse_start();
        repeat (4) tick_once();
        chk("R7", "triangle halted at 0", count, 0);
        tick_once(); chk("R7", "triangle stays 0", count, 0);
        pulse_start();
        chk("R8", "restart dir up", dir_up, 1);
        tick_once(); chk("R8", "restart counts up", count, 1);
    endtask

    task automatic t_pin();
        do_reset();
        write_cfg(2'b10, 1'b0, 1'b1);
        cmp_val = 16'd2;
        set_pin(1'b1);
        pulse_start();
        tick_once(); chk("R5", "pin up 1", count, 1);
        chk("R5", "dir follows pin 1", dir_up, 1);
        tick_once(); chk("R5", "pin up 2", count, 2);
        chk("R10", "match in pin mode", match_pulse, 1);
        tick_once(); chk("R5", "no clear at match", count, 3);
        set_pin(1'b0);
        chk("R5", "dir follows pin 0", dir_up, 0);
        tick_once(); chk("R5", "pin down", count, 2);
        tick_once(); chk("R5", "pin down again", count, 1);
    endtask

    task automatic t_pin_stop();
        do_reset();
        write_cfg(2'b10, 1'b0, 1'b0);
        set_pin(1'b1);
        pulse_start();
        tick_once();
        set_pin(1'b0);
        tick_once(); chk("R7", "pin mode lands 0", count, 0);
        tick_once(); chk("R7", "pin mode halted", count, 0);
        pulse_start();
        chk("R8", "restart dir from pin", dir_up, 0);
        tick_once(); chk("R8", "restart counts down", count, 16'hFFFF);
    endtask

    task automatic t_gate();
        do_reset();
        write_cfg(2'b00, 1'b1, 1'b1);
        cmp_val = 16'd9;
        set_pin(1'b0);
        pulse_start();
        tick_once(); tick_once();
        chk("R6", "gated off", count, 0);
        set_pin(1'b1);
        tick_once(); chk("R6", "gate open", count, 1);
        write_cfg(2'b00, 1'b0, 1'b1);
        set_pin(1'b0);
        tick_once(); chk("R6", "gate disabled", count, 2);
    endtask

    task automatic t_sync();
        do_reset();
        write_cfg(2'b00, 1'b1, 1'b1);
        cmp_val = 16'd9;
        pulse_start();
        @(negedge clk);
        ext_pin = 1'b1; tick = 1'b1;
        @(negedge clk); chk("R11", "edge 1", count, 0);
        @(negedge clk); chk("R11", "edge 2", count, 0);
        @(negedge clk); chk("R11", "edge 3", count, 1);
        tick = 1'b0;
    endtask

    task automatic t_err();
        do_reset();
        write_cfg(2'b00, 1'b0, 1'b1);
        write_cfg(2'b11, 1'b1, 1'b0);
        chk("R9", "err set", mode_err, 1);
        cmp_val = 16'd1;
        pulse_start();
        tick_once(); tick_once();
        chk("R9", "still up mode", count, 0);
        tick_once(); chk("R9", "run-through kept", count, 1);
        write_cfg(2'b01, 1'b0, 1'b1);
        chk("R9", "err sticky", mode_err, 1);
    endtask

    initial begin
        t_reset();
        t_up();
        t_up_stop();
        t_tri();
        t_tri_stop();
        t_pin();
        t_pin_stop();
        t_gate();
        t_sync();
        t_err();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (R1..all): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule